// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit operand address for a small 16-bit-address processor core. The core's decoder presents a mode code, a base selector and the offset bytes it has already fetched, together with the current index registers, stack pointer, program counter and accumulators. The block answers with the effective address, and for the auto-modify modes it also returns the new base value and a one-cycle enable.

Two modes fetch a 16-bit pointer from memory before the address is known. For these the block runs a byte-wide request/acknowledge read port and signals completion only after both pointer bytes have arrived. While such a read is in progress the block reports itself busy and ignores new requests.

The base selector codes are X = 0, Y = 1, SP = 2 and PC = 3. D is the concatenation {A, B}, with A as the high byte. All address arithmetic wraps modulo 65536.

Top module: `ea_gen`

## Requirements
- R1: Mode 0 (page-zero) gives an address of `opnd[7:0]` zero-extended to 16 bits.
- R2: Mode 1 (absolute) uses `opnd` unchanged as the address.
- R3: Mode 2 gives PC plus the sign-extended `opnd[7:0]`. Mode 3 gives PC plus `opnd`.
- R4: Modes 4, 5 and 6 add the sign-extended `opnd[4:0]`, the sign-extended `opnd[8:0]` and the full `opnd` respectively to the selected base.
- R5: Modes 7 and 8 add A or B, zero-extended, to the base. Mode 9 adds D to the base.
- R6: The step equals `step_n`+1. Modes 10 (pre-increment) and 11 (pre-decrement) give an address of base plus or minus the step. Modes 12 (post-increment) and 13 (post-decrement) give the unmodified base. In all four modes `wb_val` is base plus or minus the step.
- R7: `wb_en` is high for exactly the one cycle in which `done` reports one of modes 10 to 13, with `wb_sel` equal to the base selector. `wb_en` is never raised for any other mode, nor when the base selector is PC (3).
- R8: For mode 14 (base plus `opnd`, indirect) and mode 15 (base plus D, indirect), `rd_req` rises in the cycle after the accepted start, carrying that sum on `rd_addr`. `rd_req` and `rd_addr` then hold until `rd_ack`.
- R9: The pointer is big-endian. After the first acknowledge, `rd_addr` advances by one. In the cycle after the second acknowledge, `done` rises with `ea` equal to {first byte, second byte} and `rd_req` falls.
- R10: For modes 0 to 13, `done` and `ea` appear in the cycle after `start` is sampled with `busy` low. `done` is otherwise low.
- R11: `busy` is high from the cycle after an indirect start until the cycle in which its `done` appears. A `start` sampled while busy has no effect on any output.
- R12: Synchronous reset clears `done`, `ea`, `wb_en`, `wb_val`, `wb_sel`, `rd_req`, `rd_addr` and `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an address computation |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 2 | Base register selector |
| step_n | input | 3 | Auto-modify step minus one |
| opnd | input | 16 | Offset or operand bytes from the instruction stream |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| rd_ack | input | 1 | Pointer byte returned |
| rd_data | input | 8 | Pointer byte value |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte address |
| busy | output | 1 | Indirect fetch in progress |
| done | output | 1 | Effective address valid strobe |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base writeback enable |
| wb_sel | output | 2 | Base register to write |
| wb_val | output | 16 | New base value |

## Verification
Two events can coincide. The second pointer acknowledge can arrive in the same cycle as a new `start`, and that start must be dropped because `busy` is still high. Likewise, `done` from an auto-modify mode must carry its writeback in the very same cycle. The bench issues random starts on every cycle and acknowledges pointer bytes at random, so both collisions occur many times. A behavioural model predicts all outputs from each edge's inputs, and the bench compares them on every clock.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_PAGE0 = 4'd0, M_ABS = 4'd1, M_REL8 = 4'd2, M_REL16 = 4'd3,
    M_OFS5 = 4'd4, M_OFS9 = 4'd5, M_OFS16 = 4'd6,
    M_ACCA = 4'd7, M_ACCB = 4'd8, M_ACCD = 4'd9,
    M_PREINC = 4'd10, M_PREDEC = 4'd11, M_POSTINC = 4'd12, M_POSTDEC = 4'd13,
    M_IND16 = 4'd14, M_INDD = 4'd15
  } mode_e;

  localparam logic [1:0] SEL_X  = 2'd0;
  localparam logic [1:0] SEL_Y  = 2'd1;
  localparam logic [1:0] SEL_SP = 2'd2;
  localparam logic [1:0] SEL_PC = 2'd3;

  function automatic logic is_auto(input mode_e m);
    return (m == M_PREINC) || (m == M_PREDEC) || (m == M_POSTINC) || (m == M_POSTDEC);
  endfunction

  function automatic logic is_indirect(input mode_e m);
    return (m == M_IND16) || (m == M_INDD);
  endfunction
endpackage

// File: rtl/ea_base_mux.sv
module ea_base_mux #(
  parameter int AW = 16
) (
  input  logic [1:0]    sel,
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] base
);
  always_comb begin
    unique case (sel)
      ea_pkg::SEL_X:  base = x;
      ea_pkg::SEL_Y:  base = y;
      ea_pkg::SEL_SP: base = sp;
      default:        base = pc;
    endcase
  end
endmodule

// File: rtl/ea_offset_calc.sv
module ea_offset_calc #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int SW  = 3,
  parameter int S5  = 5,
  parameter int S9  = 9
) (
  input  ea_pkg::mode_e mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] opnd,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  input  logic [SW-1:0] step_n,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] new_base
);
  import ea_pkg::*;

  localparam int ZX = AW - DW;

  logic [AW-1:0] sx8, sx5, sx9, zx8, za, zb, dval, step, bplus, bminus;

  assign sx8    = {{ZX{opnd[DW-1]}}, opnd[DW-1:0]};
  assign zx8    = {{ZX{1'b0}}, opnd[DW-1:0]};
  assign sx5    = {{(AW-S5){opnd[S5-1]}}, opnd[S5-1:0]};
  assign sx9    = {{(AW-S9){opnd[S9-1]}}, opnd[S9-1:0]};
  assign za     = {{ZX{1'b0}}, acc_a};
  assign zb     = {{ZX{1'b0}}, acc_b};
  assign dval   = AW'({acc_a, acc_b});
  assign step   = {{(AW-SW){1'b0}}, step_n} + AW'(1);
  assign bplus  = base + step;
  assign bminus = base - step;

  always_comb begin
    unique case (mode)
      M_PAGE0:   addr = zx8;
      M_ABS:     addr = opnd;
      M_REL8:    addr = pc + sx8;
      M_REL16:   addr = pc + opnd;
      M_OFS5:    addr = base + sx5;
      M_OFS9:    addr = base + sx9;
      M_OFS16:   addr = base + opnd;
      M_ACCA:    addr = base + za;
      M_ACCB:    addr = base + zb;
      M_ACCD:    addr = base + dval;
      M_PREINC:  addr = bplus;
      M_PREDEC:  addr = bminus;
      M_POSTINC: addr = base;
      M_POSTDEC: addr = base;
      M_IND16:   addr = base + opnd;
      default:   addr = base + dval;
    endcase
  end

  assign new_base = ((mode == M_PREINC) || (mode == M_POSTINC)) ? bplus : bminus;
endmodule

// File: rtl/ea_ptr_fetch.sv
module ea_ptr_fetch #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] ptr_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          fin,
  output logic [AW-1:0] ptr_val
);
  typedef enum logic [1:0] {F_IDLE, F_HI, F_LO} fst_e;
  fst_e          st;
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      hi_q    <= '0;
    end else begin
      unique case (st)
        F_IDLE: if (go) begin
          rd_req  <= 1'b1;
          rd_addr <= ptr_addr;
          st      <= F_HI;
        end
        F_HI: if (rd_ack) begin
          hi_q    <= rd_data;
          rd_addr <= rd_addr + AW'(1);
          st      <= F_LO;
        end
        default: if (rd_ack) begin
          rd_req <= 1'b0;
          st     <= F_IDLE;
        end
      endcase
    end
  end

  assign busy    = (st != F_IDLE);
  assign fin     = (st == F_LO) && rd_ack;
  assign ptr_val = AW'({hi_q, rd_data});
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    base_sel,
  input  logic [SW-1:0] step_n,
  input  logic [AW-1:0] opnd,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [AW-1:0] reg_pc,
  input  logic [DW-1:0] acc_a,
  input  logic [DW-1:0] acc_b,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val
);
  import ea_pkg::*;

  mode_e         m;
  logic [AW-1:0] base, addr, new_base, ptr_val;
  logic          go_dir, go_ind, fin;

  assign m = mode_e'(mode);

  ea_base_mux #(.AW(AW)) u_mux (
    .sel(base_sel), .x(reg_x), .y(reg_y), .sp(reg_sp), .pc(reg_pc), .base(base)
  );

  ea_offset_calc #(.AW(AW), .DW(DW), .SW(SW)) u_calc (
    .mode(m), .base(base), .pc(reg_pc), .opnd(opnd), .acc_a(acc_a), .acc_b(acc_b),
    .step_n(step_n), .addr(addr), .new_base(new_base)
  );

  assign go_dir = start && !busy && !is_indirect(m);
  assign go_ind = start && !busy && is_indirect(m);

  ea_ptr_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk(clk), .rst(rst), .go(go_ind), .ptr_addr(addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy),
    .fin(fin), .ptr_val(ptr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      ea     <= '0;
      wb_en  <= 1'b0;
      wb_sel <= '0;
      wb_val <= '0;
    end else begin
      done  <= go_dir || fin;
      wb_en <= go_dir && is_auto(m) && (base_sel != SEL_PC);
      if (go_dir) begin
        ea <= addr;
      end else if (fin) begin
        ea <= ptr_val;
      end
      if (go_dir && is_auto(m)) begin
        wb_sel <= base_sel;
        wb_val <= new_base;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    mode,
  input logic          busy,
  input logic          done,
  input logic          wb_en,
  input logic [1:0]    wb_sel,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr
);
  // R7
  wb_with_done_chk: assert property (@(posedge clk) disable iff (rst) wb_en |-> done);
  // R7
  wb_not_pc_chk: assert property (@(posedge clk) disable iff (rst) wb_en |-> (wb_sel != 2'd3));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  // R8
  ind_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode >= 4'd14) |=> rd_req);
  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ack) |=> (done || rd_addr == $past(rd_addr) + AW'(1)));
  // R10
  direct_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode < 4'd14) |=> done);
  // R11
  req_busy_chk: assert property (@(posedge clk) disable iff (rst) rd_req |-> busy);
endmodule

bind ea_gen ea_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .busy(busy), .done(done),
  .wb_en(wb_en), .wb_sel(wb_sel), .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, rd_ack = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  base_sel = '0;
  logic [2:0]  step_n = '0;
  logic [15:0] opnd = '0, reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
  logic [7:0]  acc_a = '0, acc_b = '0, rd_data;
  logic        rd_req, busy, done, wb_en;
  logic [15:0] rd_addr, ea, wb_val;
  logic [1:0]  wb_sel;

  int checks = 0, bad = 0, cyc = 0;
  bit ack_rand = 1'b1;

  ea_gen uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base_sel(base_sel),
    .step_n(step_n), .opnd(opnd), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
    .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy), .done(done), .ea(ea),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int memf(input int a);
    return ((a * 37) + (a >> 8) * 11 + 5) % 256;
  endfunction

  assign rd_data = 8'(memf(int'(rd_addr)));

  function automatic int sx(input int v, input int bits);
    int lim = 1 << (bits - 1);
    int m = v % (1 << bits);
    return (m >= lim) ? m - (1 << bits) : m;
  endfunction

  function automatic int w16(input int v);
    return ((v % 65536) + 65536) % 65536;
  endfunction

  function automatic int base_now();
    case (base_sel)
      2'd0: return int'(reg_x);
      2'd1: return int'(reg_y);
      2'd2: return int'(reg_sp);
      default: return int'(reg_pc);
    endcase
  endfunction

  function automatic string tag_of(input int md);
    if (md == 0) return "R1";
    if (md == 1) return "R2";
    if (md <= 3) return "R3";
    if (md <= 6) return "R4";
    if (md <= 9) return "R5";
    if (md <= 13) return "R6";
    return "R9";
  endfunction

  function automatic int ref_addr();
    int b = base_now();
    int st = int'(step_n) + 1;
    int d = int'(acc_a) * 256 + int'(acc_b);
    int o = int'(opnd);
    case (int'(mode))
      0: return o % 256;
      1: return o;
      2: return w16(int'(reg_pc) + sx(o, 8));
      3: return w16(int'(reg_pc) + o);
      4: return w16(b + sx(o, 5));
      5: return w16(b + sx(o, 9));
      6: return w16(b + o);
      7: return w16(b + int'(acc_a));
      8: return w16(b + int'(acc_b));
      9: return w16(b + d);
      10: return w16(b + st);
      11: return w16(b - st);
      12, 13: return b;
      14: return w16(b + o);
      default: return w16(b + d);
    endcase
  endfunction

  // behavioural reference
  int    m_state = 0, m_hi = 0;
  int    e_ea = 0, e_addr = 0, e_wbv = 0, e_wbs = 0;
  bit    e_done = 0, e_wb = 0, e_req = 0;
  string e_tag = "R10";

  always @(posedge clk) begin
    if (rst) begin
      m_state <= 0; e_done <= 0; e_wb <= 0; e_req <= 0; e_addr <= 0; e_ea <= 0;
    end else begin
      e_done <= 0;
      e_wb   <= 0;
      case (m_state)
        0: if (start) begin
          if (mode >= 4'd14) begin
            e_req <= 1; e_addr <= ref_addr(); m_state <= 1; e_tag <= tag_of(int'(mode));
          end else begin
            e_done <= 1; e_ea <= ref_addr(); e_tag <= tag_of(int'(mode));
            if (mode >= 4'd10 && base_sel != 2'd3) begin
              e_wb  <= 1;
              e_wbs <= int'(base_sel);
              e_wbv <= (mode == 4'd10 || mode == 4'd12) ?
                       w16(base_now() + int'(step_n) + 1) : w16(base_now() - int'(step_n) - 1);
            end
          end
        end
        1: if (rd_ack) begin
          m_hi <= memf(e_addr); e_addr <= w16(e_addr + 1); m_state <= 2;
        end
        default: if (rd_ack) begin
          e_req <= 0; e_done <= 1; e_ea <= m_hi * 256 + memf(e_addr); m_state <= 0;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", rq, cyc, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(done == e_done, "R10", int'(done), int'(e_done));
      if (e_done) chk(int'(ea) == e_ea, e_tag, int'(ea), e_ea);
      chk(wb_en == e_wb, "R7", int'(wb_en), int'(e_wb));
      if (e_wb) begin
        chk(int'(wb_val) == e_wbv, "R6", int'(wb_val), e_wbv);
        chk(int'(wb_sel) == e_wbs, "R7", int'(wb_sel), e_wbs);
      end
      chk(rd_req == e_req, "R8", int'(rd_req), int'(e_req));
      if (e_req) chk(int'(rd_addr) == e_addr, "R8", int'(rd_addr), e_addr);
      chk(busy == (m_state != 0), "R11", int'(busy), int'(m_state != 0));
    end
    rd_ack <= rd_req && (ack_rand ? ($urandom % 3 != 0) : 1'b1);
  end

  task automatic op(input int md, input int sel, input int n, input int o);
    @(negedge clk);
    mode = 4'(md); base_sel = 2'(sel); step_n = 3'(n); opnd = 16'(o); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!done && !wb_en && !rd_req && !busy && ea == 0 && wb_val == 0 && wb_sel == 0 && rd_addr == 0,
        "R12", int'(ea), 0);
    rst = 1'b0;
    reg_x = 16'h1234; reg_y = 16'hFFFE; reg_sp = 16'h0003; reg_pc = 16'h8000;
    acc_a = 8'hF0; acc_b = 8'h81;
    op(0, 0, 0, 16'hABCD);               // R1
    op(1, 0, 0, 16'hBEEF);               // R2
    op(2, 0, 0, 16'h0080);               // R3 negative rel
    op(3, 0, 0, 16'h9000);               // R3 wrap
    op(4, 1, 0, 16'h0010);               // R4 -16 from Y
    op(5, 2, 0, 16'h01FF);               // R4 -1 wraps SP
    op(6, 0, 0, 16'hF000);               // R4
    op(7, 1, 0, 0);                      // R5 A unsigned
    op(8, 3, 0, 0);                      // R5 B from PC
    op(9, 0, 0, 0);                      // R5 D
    op(10, 1, 7, 0);                     // R6 pre-inc wraps
    op(11, 2, 7, 0);                     // R6 pre-dec wraps
    op(12, 0, 0, 0);                     // R6 post-inc
    op(13, 1, 3, 0);                     // R6 post-dec
    op(10, 3, 2, 0);                     // R7 PC: no writeback
    op(14, 1, 0, 16'h0003);              // R8 R9 indirect wraps
    drain();
    op(15, 0, 0, 0);                     // R8 R9 D-indirect
    // R11 starts while busy are ignored
    @(negedge clk); mode = 4'd1; opnd = 16'h5555; start = 1'b1;
    repeat (6) @(negedge clk);
    start = 1'b0;
    drain();
    ack_rand = 1'b0;
    op(14, 2, 0, 16'hFFFF);              // R9 with immediate acks
    drain();
    ack_rand = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start = ($urandom % 2) == 1;
      mode = 4'($urandom); base_sel = 2'($urandom); step_n = 3'($urandom);
      opnd = 16'($urandom); reg_x = 16'($urandom); reg_y = 16'($urandom);
      reg_sp = 16'($urandom); reg_pc = 16'($urandom);
      acc_a = 8'($urandom); acc_b = 8'($urandom);
    end
    start = 1'b0;
    drain();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule